// File: doc/BRIEF.md
# Local Bus Register Bank

This block is a cluster of control and status registers that a processor reaches over a simple local bus, while on-chip logic uses the same registers directly. A request is a valid strobe, a read/write opcode, an address and write data, all presented together in one cycle. The response is read data, a one-cycle acknowledge and a level interrupt. A registered stage sits on the request side and another on the response side, so an access is acknowledged two clock edges after it is presented.

The cluster holds five kinds of register, and each kind behaves differently on the bus. Read-write control registers may be narrower than the bus. Status registers are read-only from the bus. An event register collects bits from local logic and clears itself when the bus reads it. An accumulator sums values supplied by local logic. An interrupt flag register drives the interrupt output. A base parameter moves the whole cluster within the bus address space.

Top module: `csr_bank`

## Requirements
- R1: A request presented with `lb_valid` high at a rising edge produces `lb_ack` high for exactly one cycle, starting at the second rising edge after it. `lb_ack` is low in every other cycle. `lb_rdata` is valid in the acknowledge cycle.
- R2: The address decodes as BASE plus a local slot. The slots are: read-write register i at i, status register i at NUM_RW+i, the event register at NUM_RW+NUM_RO, the accumulator one slot above that, and the flag register one slot above the accumulator. With the defaults the addresses are 0x40/0x41, 0x42/0x43, 0x44, 0x45 and 0x46.
- R3: A bus write to a read-write register stores the low RW_W bits of the write data. A bus read of that register returns its value zero-extended at the top, so with the defaults bits 15:12 read as 0.
- R4: A local write to a read-write register shows on `rw_value` after the next edge. When a bus write and a local write hit the same register in the same cycle, the bus value is stored.
- R5: A local write loads a status register. A bus read returns that value. A bus write to a status address leaves both the read value and `sts_value` unchanged.
- R6: Bits pulsed on `evt_set` are ORed into the event register. A bus read returns the register and then clears it. Bits set in the same cycle as the clearing read survive that read. A bus write to the event register has no effect.
- R7: While `acc_add_en` is high, the accumulator adds `acc_add_val` modulo 2^ACC_W. A bus read returns the sum. A bus write loads the accumulator, and it wins over an add in the same cycle.
- R8: A pulse on `flag_set` bit k sets flag k. A bus write with bit k at 1 clears flag k, but a set in the same cycle wins. `lb_irq` is the OR of all flags. A bus read of the flag register returns the flags in its low IRQ_W bits.
- R9: A request to an address outside the cluster is still acknowledged, and a read returns 0. Every write returns 0 on `lb_rdata`.
- R10: After reset every register, `lb_ack`, `lb_irq` and `lb_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_valid | input | 1 | Bus request strobe |
| lb_write | input | 1 | 1 = write, 0 = read |
| lb_addr | input | ADDR_W | Bus address |
| lb_wdata | input | DATA_W | Bus write data |
| lb_rdata | output | DATA_W | Bus read data |
| lb_ack | output | 1 | Acknowledge pulse |
| lb_irq | output | 1 | OR of interrupt flags |
| rw_wr_en | input | NUM_RW | Local write enables for read-write registers |
| rw_wr_data | input | NUM_RW*RW_W | Local write data, register i at bits i*RW_W |
| rw_value | output | NUM_RW*RW_W | Current read-write register values |
| sts_wr_en | input | NUM_RO | Local load enables for status registers |
| sts_wr_data | input | NUM_RO*DATA_W | Status load data |
| sts_value | output | NUM_RO*DATA_W | Current status values |
| evt_set | input | DATA_W | Event bits to OR into the event register |
| acc_add_en | input | 1 | Accumulator add strobe |
| acc_add_val | input | ACC_W | Accumulator addend |
| acc_value | output | ACC_W | Current accumulator sum |
| flag_set | input | IRQ_W | Interrupt flag set pulses |

## Verification
A table of plain bus accesses runs first. It separates correct decode from aliasing by writing two neighbouring read-write registers with distinct values and reading back both. It also shows zero-extension and the ignored status write, and reaches addresses just below and just above the cluster. Directed sequences then place a local action in the same cycle that a bus request is decoded. Each of these sequences tells one ordering apart from the other: bus write against local write, clearing read against a new event, load against add, and flag clear against flag set. Accumulator wrap and the two-edge acknowledge timing are checked along the way.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } lb_op_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RW,
        RG_RO,
        RG_EVT,
        RG_ACC,
        RG_FLAG
    } region_e;

endpackage

// File: rtl/csr_req_stage.sv
module csr_req_stage
    import csr_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              out_valid,
    output lb_op_e            out_op,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata
);

    typedef struct packed {
        logic              valid;
        lb_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d.valid = in_valid;
        req_d.op    = in_write ? OP_WRITE : OP_READ;
        req_d.addr  = in_addr;
        req_d.wdata = in_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign out_valid = req_q.valid;
    assign out_op    = req_q.op;
    assign out_addr  = req_q.addr;
    assign out_wdata = req_q.wdata;

endmodule

// File: rtl/csr_rsp_stage.sv
module csr_rsp_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_ack,
    input  logic [DATA_W-1:0] in_rdata,
    output logic              out_ack,
    output logic [DATA_W-1:0] out_rdata
);

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d.ack   = in_ack;
        rsp_d.rdata = in_ack ? in_rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign out_ack   = rsp_q.ack;
    assign out_rdata = rsp_q.rdata;

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
    import csr_bank_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 16,
    parameter int              RW_W   = 12,
    parameter int              ACC_W  = 16,
    parameter int              IRQ_W  = 4,
    parameter int              NUM_RW = 2,
    parameter int              NUM_RO = 2,
    parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  lb_op_e                   req_op,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_ack,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     irq,
    input  logic [NUM_RW-1:0]        rw_wr_en,
    input  logic [NUM_RW*RW_W-1:0]   rw_wr_data,
    output logic [NUM_RW*RW_W-1:0]   rw_value,
    input  logic [NUM_RO-1:0]        sts_wr_en,
    input  logic [NUM_RO*DATA_W-1:0] sts_wr_data,
    output logic [NUM_RO*DATA_W-1:0] sts_value,
    input  logic [DATA_W-1:0]        evt_set,
    input  logic                     acc_add_en,
    input  logic [ACC_W-1:0]         acc_add_val,
    output logic [ACC_W-1:0]         acc_value,
    input  logic [IRQ_W-1:0]         flag_set
);

    localparam int RO_OFF   = NUM_RW;
    localparam int EVT_OFF  = NUM_RW + NUM_RO;
    localparam int ACC_OFF  = EVT_OFF + 1;
    localparam int FLAG_OFF = ACC_OFF + 1;

    typedef struct packed {
        logic [NUM_RW-1:0][RW_W-1:0]   rw;
        logic [NUM_RO-1:0][DATA_W-1:0] ro;
        logic [DATA_W-1:0]             evt;
        logic [ACC_W-1:0]              acc;
        logic [IRQ_W-1:0]              flag;
    } bank_t;

    bank_t             st_d, st_q;
    logic [ADDR_W-1:0] off, idx;
    region_e           rgn;
    logic              rd, wr;
    logic [DATA_W-1:0] rdata;

    // Address decode: subtract the base once, then classify the slot.
    always_comb begin
        off = req_addr - BASE;
        idx = '0;
        if (int'(off) < RO_OFF) begin
            rgn = RG_RW;
            idx = off;
        end else if (int'(off) < EVT_OFF) begin
            rgn = RG_RO;
            idx = off - ADDR_W'(RO_OFF);
        end else if (int'(off) == EVT_OFF) begin
            rgn = RG_EVT;
        end else if (int'(off) == ACC_OFF) begin
            rgn = RG_ACC;
        end else if (int'(off) == FLAG_OFF) begin
            rgn = RG_FLAG;
        end else begin
            rgn = RG_NONE;
        end
        rd = req_valid && (req_op == OP_READ);
        wr = req_valid && (req_op == OP_WRITE);
    end

    // Next state: local action first, bus action applied over it.
    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rw_wr_en[i]) st_d.rw[i] = rw_wr_data[i*RW_W +: RW_W];
            if (rgn == RG_RW && idx == ADDR_W'(i)) begin
                if (wr) st_d.rw[i] = req_wdata[RW_W-1:0];
                if (rd) rdata = DATA_W'(st_q.rw[i]);
            end
        end
        for (int i = 0; i < NUM_RO; i++) begin
            if (sts_wr_en[i]) st_d.ro[i] = sts_wr_data[i*DATA_W +: DATA_W];
            if (rd && rgn == RG_RO && idx == ADDR_W'(i)) rdata = st_q.ro[i];
        end
        if (rd && rgn == RG_EVT) begin
            rdata     = st_q.evt;
            st_d.evt  = '0;
        end
        st_d.evt = st_d.evt | evt_set;
        if (acc_add_en) st_d.acc = st_q.acc + acc_add_val;
        if (rgn == RG_ACC) begin
            if (wr) st_d.acc = req_wdata[ACC_W-1:0];
            if (rd) rdata = DATA_W'(st_q.acc);
        end
        if (rgn == RG_FLAG) begin
            if (wr) st_d.flag = st_q.flag & ~req_wdata[IRQ_W-1:0];
            if (rd) rdata = DATA_W'(st_q.flag);
        end
        st_d.flag = st_d.flag | flag_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_ack   = req_valid;
    assign rsp_rdata = rdata;
    assign irq       = |st_q.flag;
    assign acc_value = st_q.acc;

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        assign rw_value[g*RW_W +: RW_W] = st_q.rw[g];

        assert_rw_bus_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && rw_wr_en[g] && req_addr == BASE + ADDR_W'(g))
            |=> st_q.rw[g] == $past(req_wdata[RW_W-1:0]));
    end

    for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
        assign sts_value[g*DATA_W +: DATA_W] = st_q.ro[g];

        assert_sts_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !sts_wr_en[g] && req_addr == BASE + ADDR_W'(RO_OFF + g))
            |=> $stable(st_q.ro[g]));
    end

    assert_evt_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && req_addr == BASE + ADDR_W'(EVT_OFF) && evt_set == '0)
        |=> st_q.evt == '0);

    assert_flag_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> irq);

endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 16,
    parameter int              RW_W   = 12,
    parameter int              ACC_W  = 16,
    parameter int              IRQ_W  = 4,
    parameter int              NUM_RW = 2,
    parameter int              NUM_RO = 2,
    parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lb_valid,
    input  logic                     lb_write,
    input  logic [ADDR_W-1:0]        lb_addr,
    input  logic [DATA_W-1:0]        lb_wdata,
    output logic [DATA_W-1:0]        lb_rdata,
    output logic                     lb_ack,
    output logic                     lb_irq,
    input  logic [NUM_RW-1:0]        rw_wr_en,
    input  logic [NUM_RW*RW_W-1:0]   rw_wr_data,
    output logic [NUM_RW*RW_W-1:0]   rw_value,
    input  logic [NUM_RO-1:0]        sts_wr_en,
    input  logic [NUM_RO*DATA_W-1:0] sts_wr_data,
    output logic [NUM_RO*DATA_W-1:0] sts_value,
    input  logic [DATA_W-1:0]        evt_set,
    input  logic                     acc_add_en,
    input  logic [ACC_W-1:0]         acc_add_val,
    output logic [ACC_W-1:0]         acc_value,
    input  logic [IRQ_W-1:0]         flag_set
);

    localparam int SLOTS = NUM_RW + NUM_RO + 3;

    logic              q_valid;
    lb_op_e            q_op;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic              d_ack;
    logic [DATA_W-1:0] d_rdata;

    csr_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) req_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(lb_valid), .in_write(lb_write), .in_addr(lb_addr), .in_wdata(lb_wdata),
        .out_valid(q_valid), .out_op(q_op), .out_addr(q_addr), .out_wdata(q_wdata)
    );

    csr_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW_W(RW_W), .ACC_W(ACC_W), .IRQ_W(IRQ_W),
        .NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .BASE(BASE)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(q_valid), .req_op(q_op), .req_addr(q_addr), .req_wdata(q_wdata),
        .rsp_ack(d_ack), .rsp_rdata(d_rdata), .irq(lb_irq),
        .rw_wr_en(rw_wr_en), .rw_wr_data(rw_wr_data), .rw_value(rw_value),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_value(sts_value),
        .evt_set(evt_set), .acc_add_en(acc_add_en), .acc_add_val(acc_add_val),
        .acc_value(acc_value), .flag_set(flag_set)
    );

    csr_rsp_stage #(.DATA_W(DATA_W)) rsp_i (
        .clk(clk), .rst_n(rst_n),
        .in_ack(d_ack), .in_rdata(d_rdata),
        .out_ack(lb_ack), .out_rdata(lb_rdata)
    );

    logic [ADDR_W-1:0] lb_off;
    logic              lb_mapped;
    assign lb_off    = lb_addr - BASE;
    assign lb_mapped = int'(lb_off) < SLOTS;

    assert_ack_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lb_valid |=> ##1 lb_ack);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_valid && !lb_write && !lb_mapped) |=> ##1 (lb_ack && lb_rdata == '0));

endmodule

// File: tb/csr_bank_tb.sv
module csr_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int RW_W   = 12;
    localparam int ACC_W  = 16;
    localparam int IRQ_W  = 4;
    localparam int NUM_RW = 2;
    localparam int NUM_RO = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic                     lb_valid = 1'b0, lb_write = 1'b0;
    logic [ADDR_W-1:0]        lb_addr = '0;
    logic [DATA_W-1:0]        lb_wdata = '0;
    logic [DATA_W-1:0]        lb_rdata;
    logic                     lb_ack, lb_irq;
    logic [NUM_RW-1:0]        rw_wr_en = '0;
    logic [NUM_RW*RW_W-1:0]   rw_wr_data = '0;
    logic [NUM_RW*RW_W-1:0]   rw_value;
    logic [NUM_RO-1:0]        sts_wr_en = '0;
    logic [NUM_RO*DATA_W-1:0] sts_wr_data = '0;
    logic [NUM_RO*DATA_W-1:0] sts_value;
    logic [DATA_W-1:0]        evt_set = '0;
    logic                     acc_add_en = 1'b0;
    logic [ACC_W-1:0]         acc_add_val = '0;
    logic [ACC_W-1:0]         acc_value;
    logic [IRQ_W-1:0]         flag_set = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
        .lb_rdata(lb_rdata), .lb_ack(lb_ack), .lb_irq(lb_irq),
        .rw_wr_en(rw_wr_en), .rw_wr_data(rw_wr_data), .rw_value(rw_value),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_value(sts_value),
        .evt_set(evt_set), .acc_add_en(acc_add_en), .acc_add_val(acc_add_val),
        .acc_value(acc_value), .flag_set(flag_set)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Local side action applied in the cycle the bus request is decoded.
    // kind: 0 none, 1 rw0 write, 2 acc add, 3 event set, 4 flag set
    task automatic side_on(input int kind, input logic [DATA_W-1:0] v);
        case (kind)
            1: begin rw_wr_en[0] = 1'b1; rw_wr_data[RW_W-1:0] = v[RW_W-1:0]; end
            2: begin acc_add_en = 1'b1; acc_add_val = v; end
            3: evt_set = v;
            4: flag_set = v[IRQ_W-1:0];
            default: ;
        endcase
    endtask

    task automatic side_off();
        rw_wr_en = '0; acc_add_en = 1'b0; evt_set = '0; flag_set = '0;
    endtask

    task automatic local_pulse(input int kind, input logic [DATA_W-1:0] v);
        @(negedge clk); side_on(kind, v);
        @(negedge clk); side_off();
    endtask

    task automatic bus_op(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input int kind,
                          input logic [DATA_W-1:0] sv, output logic [DATA_W-1:0] rd);
        @(negedge clk);
        check("R1 ack idle before request", lb_ack, 0);
        lb_valid = 1'b1; lb_write = wr; lb_addr = a; lb_wdata = wd;
        @(negedge clk);
        lb_valid = 1'b0;
        check("R1 no ack one edge after request", lb_ack, 0);
        side_on(kind, sv);
        @(negedge clk);
        side_off();
        check("R1 ack two edges after request", lb_ack, 1);
        rd = lb_rdata;
    endtask

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] exp;
        logic [3:0]        req;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 8'h40, 16'hABCD, 16'h0000, 4'd3},  // R3 write rw0
        '{1'b0, 8'h40, 16'h0000, 16'h0BCD, 4'd3},  // R3 zero-extended read
        '{1'b1, 8'h41, 16'hF123, 16'h0000, 4'd2},  // R2 write rw1
        '{1'b0, 8'h41, 16'h0000, 16'h0123, 4'd2},  // R2 rw1 separate
        '{1'b0, 8'h40, 16'h0000, 16'h0BCD, 4'd2},  // R2 rw0 not aliased
        '{1'b1, 8'h42, 16'h5555, 16'h0000, 4'd5},  // R5 write status
        '{1'b0, 8'h42, 16'h0000, 16'h0000, 4'd5},  // R5 write ignored
        '{1'b0, 8'h3F, 16'h0000, 16'h0000, 4'd9},  // R9 below base
        '{1'b0, 8'h47, 16'h0000, 16'h0000, 4'd9},  // R9 just above cluster
        '{1'b1, 8'h45, 16'h0010, 16'h0000, 4'd7},  // R7 load accumulator
        '{1'b0, 8'h45, 16'h0000, 16'h0010, 4'd7},  // R7 read sum
        '{1'b0, 8'h80, 16'h0000, 16'h0000, 4'd9}   // R9 far away
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 ack", lb_ack, 0);
        check("R10 irq", lb_irq, 0);
        check("R10 rdata", lb_rdata, 0);
        check("R10 rw_value", rw_value, 0);
        check("R10 acc_value", acc_value, 0);
        check("R10 sts_value", sts_value, 0);

        for (int i = 0; i < 12; i++) begin
            bus_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, 0, '0, rd);
            check($sformatf("R%0d table[%0d]", VECS[i].req, i), rd, VECS[i].exp);
        end

        // R4 local write alone, then collision with bus write
        local_pulse(1, 16'h0777);
        check("R4 local write visible", rw_value[RW_W-1:0], 12'h777);
        bus_op(1'b1, 8'h40, 16'h0AAA, 1, 16'h0555, rd);
        bus_op(1'b0, 8'h40, 16'h0000, 0, '0, rd);
        check("R4 bus write wins", rd, 16'h0AAA);
        check("R4 rw_value after collision", rw_value[RW_W-1:0], 12'hAAA);

        // R5 status load then ignored bus write
        @(negedge clk); sts_wr_en = 2'b01; sts_wr_data[DATA_W-1:0] = 16'h1234;
        @(negedge clk); sts_wr_en = '0;
        bus_op(1'b0, 8'h42, 16'h0000, 0, '0, rd);
        check("R5 status read", rd, 16'h1234);
        bus_op(1'b1, 8'h42, 16'hFFFF, 0, '0, rd);
        bus_op(1'b0, 8'h42, 16'h0000, 0, '0, rd);
        check("R5 status after bus write", rd, 16'h1234);
        check("R5 sts_value unchanged", sts_value[DATA_W-1:0], 16'h1234);

        // R6 event register
        local_pulse(3, 16'h0003);
        local_pulse(3, 16'h0100);
        bus_op(1'b0, 8'h44, 16'h0000, 0, '0, rd);
        check("R6 accumulated events", rd, 16'h0103);
        bus_op(1'b0, 8'h44, 16'h0000, 0, '0, rd);
        check("R6 cleared after read", rd, 16'h0000);
        local_pulse(3, 16'h0001);
        bus_op(1'b0, 8'h44, 16'h0000, 3, 16'h0020, rd);
        check("R6 read during set", rd, 16'h0001);
        bus_op(1'b0, 8'h44, 16'h0000, 0, '0, rd);
        check("R6 set survives clearing read", rd, 16'h0020);
        local_pulse(3, 16'h0040);
        bus_op(1'b1, 8'h44, 16'hFFFF, 0, '0, rd);
        bus_op(1'b0, 8'h44, 16'h0000, 0, '0, rd);
        check("R6 bus write ignored", rd, 16'h0040);

        // R7 accumulator wrap and load priority
        local_pulse(2, 16'hFFF8);
        check("R7 wrap", acc_value, 16'h0008);
        local_pulse(2, 16'h0005);
        check("R7 add", acc_value, 16'h000D);
        bus_op(1'b0, 8'h45, 16'h0000, 0, '0, rd);
        check("R7 bus read sum", rd, 16'h000D);
        bus_op(1'b1, 8'h45, 16'h0100, 2, 16'h0007, rd);
        check("R9 write returns zero", rd, 16'h0000);
        check("R7 load wins over add", acc_value, 16'h0100);

        // R8 interrupt flags
        local_pulse(4, 16'h0002);
        check("R8 irq after set", lb_irq, 1);
        local_pulse(4, 16'h0008);
        bus_op(1'b0, 8'h46, 16'h0000, 0, '0, rd);
        check("R8 flags read", rd, 16'h000A);
        bus_op(1'b1, 8'h46, 16'h0002, 0, '0, rd);
        bus_op(1'b0, 8'h46, 16'h0000, 0, '0, rd);
        check("R8 clear one flag", rd, 16'h0008);
        check("R8 irq still high", lb_irq, 1);
        bus_op(1'b1, 8'h46, 16'h0008, 4, 16'h0008, rd);
        check("R8 set wins over clear", lb_irq, 1);
        bus_op(1'b1, 8'h46, 16'h0008, 0, '0, rd);
        check("R8 irq low after clear", lb_irq, 0);

        @(negedge clk);
        check("R1 ack one cycle wide", lb_ack, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule